// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

The block divides the system clock by a programmable 16-bit divisor plus one and produces a one-cycle oversampling tick. A serial transmitter and receiver use this tick to time their bits. A mode input sets how many ticks make one bit time: sixteen ticks in normal mode, or four ticks in fast mode. A separate one-cycle strobe marks the last tick of each bit time.

With divisor D, the baud rate is Fclk / (16·(D+1)) in normal mode and Fclk / (4·(D+1)) in fast mode. A load strobe writes a new divisor. The load also restarts the count, so the first tick after it comes one full new period later. A change of mode restarts the count in the same way. In normal mode the block also drives a near-square clock at sixteen times the baud rate, which can feed an infrared transceiver. This output is held low in fast mode.

Top module: `baud_tick_gen`

## Requirements
- R1: With a divisor D loaded, `tick_o` is high for one cycle out of every D+1 cycles.
- R2: The divisor is taken from `div_i` at the clock edge where `div_load_i` is high. The first `tick_o` pulse then appears D clock edges later, and every later pulse follows D+1 edges after the one before.
- R3: A divisor of 0 holds `tick_o` high on every cycle.
- R4: In normal mode (`fast_mode_i` = 0), `bit_tick_o` pulses on every 16th tick, counted from a restart. The first pulse falls on the 16th tick after the restart.
- R5: In fast mode (`fast_mode_i` = 1), `bit_tick_o` pulses on every 4th tick, counted from a restart.
- R6: A change of `fast_mode_i` with no load also restarts the block. The counter reloads the held divisor and the tick count clears, so the timing is the same as after a load.
- R7: In normal mode, `clk16_o` has a period of D+1 cycles. Each period starts high and stays high for D − floor(D/2) cycles. With D = 0 the output stays low.
- R8: In fast mode, `clk16_o` is held low.
- R9: During reset, `tick_o`, `bit_tick_o` and `clk16_o` are low, and the divisor is DIV_RST (default 9). After reset is released, the first tick appears DIV_RST edges later, and the tick period is DIV_RST+1.
- R10: `bit_tick_o` is never high unless `tick_o` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | 16 | New divisor value |
| div_load_i | input | 1 | Load strobe for `div_i`; also restarts the count |
| fast_mode_i | input | 1 | 0: 16 ticks per bit; 1: 4 ticks per bit |
| tick_o | output | 1 | Oversampling tick, one cycle wide |
| bit_tick_o | output | 1 | High on the last tick of each bit time |
| clk16_o | output | 1 | Clock at 16x the baud rate (normal mode only) |

## Verification
The hardest cases to reach are the restarts that hit the counter partway through a period. One is a divisor load that lands in the middle of a count. The other is a mode change that arrives with no load at all. In both cases the next tick must follow the new period, with no leftover from the old phase.

The stimulus loads a divisor of 5, lets it run for a few cycles, and then loads 2 before the count can expire. After that it flips only the mode input. Both times it measures the position of the first tick and of the first bit strobe from the restart edge. A table of divisor and mode pairs, including divisor 0, checks the tick spacing, the bit length and the high time of the 16x clock.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam int unsigned OSR_HI = 16;
  localparam int unsigned OSR_LO = 4;
  localparam int unsigned PH_W   = $clog2(OSR_HI);

  typedef enum logic [0:0] {
    OSR_X16 = 1'b0,
    OSR_X4  = 1'b1
  } osr_e;
endpackage

// File: rtl/bg_prescaler.sv
module bg_prescaler #(
  parameter int unsigned     DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic [DIV_W-1:0] cnt_d_o,
  output logic [DIV_W-1:0] div_d_o
);
  logic [DIV_W-1:0] cnt_q, div_q, cnt_d, div_d;

  always_comb begin
    div_d = load_i ? div_i : div_q;
    if (restart_i)          cnt_d = div_d;
    else if (cnt_q == '0)   cnt_d = div_q;
    else                    cnt_d = cnt_q - DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= DIV_RST;
      div_q <= DIV_RST;
    end else begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  assign tick_o  = (cnt_q == '0);
  assign div_q_o = div_q;
  assign cnt_d_o = cnt_d;
  assign div_d_o = div_d;

  // R2: a load resets the count to the new divisor
  assert_load_reload_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(div_i)) && (div_q == $past(div_i)));

  // R1: an expiring count reloads the full period
  assert_period_reload_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !restart_i) |=> (cnt_q == $past(div_q)));

  // R1: between restarts the count only moves down by one or wraps
  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && !restart_i) |=> (cnt_q == $past(cnt_q) - DIV_W'(1)));
endmodule

// File: rtl/bg_phase.sv
module bg_phase
  import bg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic tick_i,
  input  osr_e mode_i,
  output logic bit_tick_o
);
  logic [PH_W-1:0] ph_q, last;

  assign last = (mode_i == OSR_X4) ? PH_W'(OSR_LO - 1) : PH_W'(OSR_HI - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ph_q <= '0;
    else if (restart_i)   ph_q <= '0;
    else if (tick_i)      ph_q <= (ph_q == last) ? '0 : ph_q + PH_W'(1);
  end

  assign bit_tick_o = tick_i && (ph_q == last);

  // R10
  assert_bit_on_tick_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> tick_i);

  // R6: restart clears the tick position
  assert_phase_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (ph_q == '0));

  // R5: fast mode never runs the position past its bit length
  assert_fast_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OSR_X4 && !restart_i && $stable(mode_i)) |-> (ph_q <= PH_W'(OSR_LO - 1)));
endmodule

// File: rtl/bg_clkout.sv
module bg_clkout
  import bg_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  osr_e             mode_i,
  input  logic [DIV_W-1:0] cnt_d_i,
  input  logic [DIV_W-1:0] div_d_i,
  output logic             clk_o
);
  logic clk_q;

  // registered so the pin never carries comparator glitches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= (mode_i == OSR_X16) && (cnt_d_i > (div_d_i >> 1));
  end

  assign clk_o = clk_q;

  // R8
  assert_clk_low_fast_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OSR_X4) |=> !clk_o);

  // R7: divisor 0 cannot toggle, output rests low
  assert_clk_low_div0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_d_i == '0) |=> !clk_o);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import bg_pkg::*;
#(
  parameter int unsigned      DIV_W   = 16,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(9)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_load_i,
  input  logic             fast_mode_i,
  output logic             tick_o,
  output logic             bit_tick_o,
  output logic             clk16_o
);
  osr_e             mode_in, mode_q;
  logic             restart, tick;
  logic [DIV_W-1:0] div_q, cnt_d, div_d;

  assign mode_in = fast_mode_i ? OSR_X4 : OSR_X16;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= OSR_X16;
    else         mode_q <= mode_in;
  end

  assign restart = div_load_i || (mode_in != mode_q);

  bg_prescaler #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .load_i    (div_load_i),
    .div_i     (div_i),
    .tick_o    (tick),
    .div_q_o   (div_q),
    .cnt_d_o   (cnt_d),
    .div_d_o   (div_d)
  );

  bg_phase u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (restart),
    .tick_i     (tick),
    .mode_i     (mode_q),
    .bit_tick_o (bit_tick_o)
  );

  bg_clkout #(.DIV_W(DIV_W)) u_clk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_in),
    .cnt_d_i (cnt_d),
    .div_d_i (div_d),
    .clk_o   (clk16_o)
  );

  assign tick_o = tick;

  // R3
  assert_div0_every_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q == '0 && !restart) |=> tick_o);

  // R6: a bare mode change behaves as a reload of the held divisor
  assert_mode_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_in != mode_q && !div_load_i) |=> (tick_o == ($past(div_q) == '0)));
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] div_i = '0;
  logic        div_load_i = 1'b0;
  logic        fast_mode_i = 1'b0;
  logic        tick_o, bit_tick_o, clk16_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  baud_tick_gen u0 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_i       (div_i),
    .div_load_i  (div_load_i),
    .fast_mode_i (fast_mode_i),
    .tick_o      (tick_o),
    .bit_tick_o  (bit_tick_o),
    .clk16_o     (clk16_o)
  );

  localparam int NV = 8;
  // divisor, fast mode, expected clk16 high cycles per period
  localparam int VDIV  [NV] = '{0, 1, 2, 3, 7, 12, 0, 5};
  localparam bit VFAST [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int VCLKH [NV] = '{0, 1, 1, 2, 4, 6, 0, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at the first negedge after the restart edge
  task automatic measure(input int d, input int l, input int first_exp,
                         input int clkh, input string tag);
    int w = l * (d + 1);
    int ft = 0, fb = 0, nt = 0, nb = 0, nc = 0, bad = 0;
    for (int n = 1; n <= w; n++) begin
      if (tick_o) begin nt++; if (ft == 0) ft = n; end
      if (bit_tick_o) begin nb++; if (fb == 0) fb = n; end
      if (bit_tick_o && !tick_o) bad++;
      if (clk16_o) nc++;
      @(negedge clk_i);
    end
    check(ft == first_exp, {tag, " R2 first tick"}, ft, first_exp);
    check(nt == (w - first_exp) / (d + 1) + 1, {tag, " R1 tick count"}, nt,
          (w - first_exp) / (d + 1) + 1);
    check(fb == first_exp + (l - 1) * (d + 1), {tag, " R4/R5 first bit strobe"}, fb,
          first_exp + (l - 1) * (d + 1));
    check(nb == 1, {tag, " R4/R5 bit strobe count"}, nb, 1);
    check(nc == l * clkh, {tag, " R7/R8 clk16 high cycles"}, nc, l * clkh);
    check(bad == 0, {tag, " R10 strobe without tick"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R9: outputs quiet during reset
    check(!tick_o, "R9 tick in reset", int'(tick_o), 0);
    check(!bit_tick_o, "R9 bit strobe in reset", int'(bit_tick_o), 0);
    check(!clk16_o, "R9 clk16 in reset", int'(clk16_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    measure(9, 16, 9, 5, "R9 reset divisor");

    // table walk: load plus mode per vector
    for (int v = 0; v < NV; v++) begin
      div_i = 16'(VDIV[v]);
      fast_mode_i = VFAST[v];
      div_load_i = 1'b1;
      @(negedge clk_i);
      div_load_i = 1'b0;
      measure(VDIV[v], VFAST[v] ? 4 : 16, VDIV[v] + 1, VCLKH[v],
              VDIV[v] == 0 ? "R3 vector" : "R1 vector");
    end

    // R2: reload partway through a period
    fast_mode_i = 1'b0;
    div_i = 16'd5;
    div_load_i = 1'b1;
    @(negedge clk_i);
    div_load_i = 1'b0;
    repeat (3) @(negedge clk_i);
    div_i = 16'd2;
    div_load_i = 1'b1;
    @(negedge clk_i);
    div_load_i = 1'b0;
    measure(2, 16, 3, 1, "R2 mid-period reload");

    // R6: mode flip alone restarts with held divisor 2
    repeat (5) @(negedge clk_i);
    fast_mode_i = 1'b1;
    @(negedge clk_i);
    measure(2, 4, 3, 0, "R6 mode change");
    // R8 again after the return to normal mode, R6 back the other way
    fast_mode_i = 1'b0;
    @(negedge clk_i);
    measure(2, 16, 3, 1, "R6 mode return");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule